// File: doc/BRIEF.md
# Busbar Differential Current Evaluator

This block evaluates the differential condition of one phase in one busbar protection zone. On every sample strobe it takes one signed, normalized instantaneous current per feeder, together with one zone-membership bit per feeder. From the feeders whose bit is set it forms two quantities. The operating current is the magnitude of their signed sum. The raw restraint current is the sum of their magnitudes.

The raw restraint passes through a smoother that holds the peak and then decays it along a straight line. When a new sample's restraint is larger than the currently decayed value, that sample becomes the new peak. From then on, each further sample takes off a fixed fraction (1/TAU_SAMP) of that peak, and the value stops at zero. The operate flag is set when the operating current is above a pickup level and also above a programmable fraction of the smoothed restraint. The operating current and the smoothed restraint are also output for the trip timers that follow.

All outputs are registered and change only on the clock edge that accepts a sample, so the block runs once per sample period. The default settings are 8 feeders, 16-bit samples, and a decay time of 115 samples, which is 60 ms at 1920 samples per second.

Top module: `busdiff_eval`

## Requirements
- R1: `iop_out` equals the absolute value of the signed sum of the selected feeder samples. Feeder i is bits [i*SAMP_W +: SAMP_W] of `cur_in`, in two's complement, and is selected by `zone_en[i]`.
- R2: The raw restraint is the sum of the absolute values of the selected feeder samples. When this raw restraint is captured, `smooth_out` equals it.
- R3: With every feeder selected and every sample at the most negative code, both sums are exact. No wrap occurs, and `iop_out` never exceeds N_FEED·2^(SAMP_W-1).
- R4: The decayed value is the previous `smooth_out` reduced by the current step. When the raw restraint is greater than this decayed value, the sample is captured: `smooth_out` takes the raw value, and the step becomes floor(raw/TAU_SAMP).
- R5: When the raw restraint is not greater than the decayed value, `smooth_out` takes the decayed value. It therefore falls by the step fixed at the last capture on every accepted sample.
- R6: The decayed value is clamped at zero. Once it reaches zero it stays at zero until a capture occurs.
- R7: `operate_out` is 1 exactly when iop > `pickup` and iop·256 > `k_frac`·smooth. The comparisons are strict, and `k_frac` is an unsigned Q0.8 fraction. Both iop and smooth are the values produced for the same sample.
- R8: On cycles where `samp_vld` is 0, all outputs hold their values whatever the other inputs do.
- R9: Synchronous reset clears all outputs to zero. The first sample after reset is always captured.
- R10: A feeder whose zone bit is 0 contributes to neither the operating sum nor the restraint sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_vld | input | 1 | Sample strobe; one accepted sample per high cycle |
| cur_in | input | N_FEED*SAMP_W | Packed signed feeder samples, feeder 0 in the low bits |
| zone_en | input | N_FEED | Zone membership bit per feeder |
| pickup | input | MAG_W | Minimum operating current threshold |
| k_frac | input | K_W | Restraint slope, unsigned fraction of 256 |
| iop_out | output | MAG_W | Registered operating current |
| smooth_out | output | MAG_W | Registered smoothed restraint |
| operate_out | output | 1 | Registered operate condition |

## Verification
The bench builds the block with 3 feeders, 5-bit samples and a decay time of 4 samples. At this size every one of the eight zone masks can be swept against a dense grid of sample triples, with the slope and pickup changing from sample to sample. The short decay time means that capture, linear decay and the zero clamp all occur many times within the sweep. Directed cases cover the full negative scale on every feeder, the strict equality edges of both comparisons, and samples that are deselected.

// File: rtl/bde_pkg.sv
package bde_pkg;
  // Unsigned width holding the sum of n magnitudes of sw-bit signed samples.
  function automatic int mag_width(input int sw, input int n);
    return sw + $clog2(n);
  endfunction
endpackage

// File: rtl/bde_sum.sv
module bde_sum #(
  parameter int N_FEED = 8,
  parameter int SAMP_W = 16,
  parameter int MAG_W  = 19
) (
  input  logic [N_FEED*SAMP_W-1:0] cur_in,
  input  logic [N_FEED-1:0]        zone_en,
  output logic [MAG_W-1:0]         op_mag,
  output logic [MAG_W-1:0]         res_raw
);
  localparam int SUM_W = MAG_W + 1;

  logic signed [SUM_W-1:0] term_s [N_FEED];
  logic        [MAG_W-1:0] term_a [N_FEED];
  logic signed [SUM_W-1:0] acc_s;
  logic        [MAG_W-1:0] acc_a;

  for (genvar g = 0; g < N_FEED; g++) begin : g_feed
    logic signed [SAMP_W-1:0] smp;
    logic signed [SUM_W-1:0]  ext;
    logic signed [SUM_W-1:0]  mag;
    assign smp = cur_in[g*SAMP_W +: SAMP_W];
    assign ext = {{(SUM_W-SAMP_W){smp[SAMP_W-1]}}, smp};
    assign mag = ext[SUM_W-1] ? -ext : ext;
    assign term_s[g] = zone_en[g] ? ext : '0;
    assign term_a[g] = zone_en[g] ? mag[MAG_W-1:0] : '0;
  end

  always_comb begin
    acc_s = '0;
    acc_a = '0;
    for (int i = 0; i < N_FEED; i++) begin
      acc_s = acc_s + term_s[i];
      acc_a = acc_a + term_a[i];
    end
  end

  logic signed [SUM_W-1:0] neg_s;
  assign neg_s   = -acc_s;
  assign op_mag  = acc_s[SUM_W-1] ? neg_s[MAG_W-1:0] : acc_s[MAG_W-1:0];
  assign res_raw = acc_a;
endmodule

// File: rtl/bde_smooth.sv
module bde_smooth #(
  parameter int MAG_W    = 19,
  parameter int TAU_SAMP = 115
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [MAG_W-1:0] raw,
  output logic [MAG_W-1:0] held,
  output logic [MAG_W-1:0] held_nxt
);
  localparam logic [MAG_W-1:0] TAU_V = MAG_W'(TAU_SAMP);

  logic [MAG_W-1:0] step_q;
  logic [MAG_W-1:0] dec;
  logic             first_q;
  logic             cap;

  always_comb begin
    dec      = (held >= step_q) ? held - step_q : '0;
    cap      = first_q || (raw > dec);
    held_nxt = cap ? raw : dec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= '0;
      step_q  <= '0;
      first_q <= 1'b1;
    end else if (vld) begin
      held    <= held_nxt;
      first_q <= 1'b0;
      if (cap) step_q <= raw / TAU_V;
    end
  end
endmodule

// File: rtl/bde_cmp.sv
module bde_cmp #(
  parameter int MAG_W = 19,
  parameter int K_W   = 8
) (
  input  logic [MAG_W-1:0] iop,
  input  logic [MAG_W-1:0] smooth,
  input  logic [MAG_W-1:0] pickup,
  input  logic [K_W-1:0]   k_frac,
  output logic             operate
);
  localparam int PW = MAG_W + K_W;

  logic [PW-1:0] lhs;
  logic [PW-1:0] rhs;

  assign lhs     = {iop, {K_W{1'b0}}};
  assign rhs     = PW'(k_frac) * PW'(smooth);
  assign operate = (iop > pickup) && (lhs > rhs);
endmodule

// File: rtl/busdiff_eval.sv
module busdiff_eval #(
  parameter int N_FEED   = 8,
  parameter int SAMP_W   = 16,
  parameter int K_W      = 8,
  parameter int TAU_SAMP = 115,
  localparam int MAG_W   = bde_pkg::mag_width(SAMP_W, N_FEED)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     samp_vld,
  input  logic [N_FEED*SAMP_W-1:0] cur_in,
  input  logic [N_FEED-1:0]        zone_en,
  input  logic [MAG_W-1:0]         pickup,
  input  logic [K_W-1:0]           k_frac,
  output logic [MAG_W-1:0]         iop_out,
  output logic [MAG_W-1:0]         smooth_out,
  output logic                     operate_out
);
  logic [MAG_W-1:0] op_mag;
  logic [MAG_W-1:0] res_raw;
  logic [MAG_W-1:0] held_nxt;
  logic             op_nxt;

  bde_sum #(.N_FEED(N_FEED), .SAMP_W(SAMP_W), .MAG_W(MAG_W)) u_sum (
    .cur_in (cur_in),
    .zone_en(zone_en),
    .op_mag (op_mag),
    .res_raw(res_raw)
  );

  bde_smooth #(.MAG_W(MAG_W), .TAU_SAMP(TAU_SAMP)) u_smooth (
    .clk     (clk),
    .rst     (rst),
    .vld     (samp_vld),
    .raw     (res_raw),
    .held    (smooth_out),
    .held_nxt(held_nxt)
  );

  bde_cmp #(.MAG_W(MAG_W), .K_W(K_W)) u_cmp (
    .iop    (op_mag),
    .smooth (held_nxt),
    .pickup (pickup),
    .k_frac (k_frac),
    .operate(op_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iop_out     <= '0;
      operate_out <= 1'b0;
    end else if (samp_vld) begin
      iop_out     <= op_mag;
      operate_out <= op_nxt;
    end
  end
endmodule

// File: rtl/bde_chk.sv
module bde_chk #(
  parameter int N_FEED = 8,
  parameter int SAMP_W = 16,
  parameter int K_W    = 8,
  parameter int MAG_W  = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             vld,
  input logic [MAG_W-1:0] pickup,
  input logic [K_W-1:0]   k_frac,
  input logic [MAG_W-1:0] iop,
  input logic [MAG_W-1:0] smooth,
  input logic             operate
);
  localparam int PW = MAG_W + K_W;
  localparam logic [MAG_W:0] IOP_MAX = (MAG_W+1)'(N_FEED) << (SAMP_W-1);

  logic [MAG_W-1:0] pk_q;
  logic [K_W-1:0]   kf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pk_q <= '0;
      kf_q <= '0;
    end else if (vld) begin
      pk_q <= pickup;
      kf_q <= k_frac;
    end
  end

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (iop == '0 && smooth == '0 && !operate));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !vld |=> ($stable(iop) && $stable(smooth) && $stable(operate)));

  p_pickup_r7: assert property (@(posedge clk) disable iff (rst)
    operate |-> (iop > pk_q));

  p_slope_r7: assert property (@(posedge clk) disable iff (rst)
    operate |-> ({iop, {K_W{1'b0}}} > PW'(kf_q) * PW'(smooth)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    {1'b0, iop} <= IOP_MAX);
endmodule

bind busdiff_eval bde_chk #(.N_FEED(N_FEED), .SAMP_W(SAMP_W), .K_W(K_W), .MAG_W(MAG_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .vld    (samp_vld),
  .pickup (pickup),
  .k_frac (k_frac),
  .iop    (iop_out),
  .smooth (smooth_out),
  .operate(operate_out)
);

// File: tb/tb_busdiff_eval.sv
module tb_busdiff_eval;
  localparam int NF  = 3;
  localparam int SW  = 5;
  localparam int KW  = 8;
  localparam int TAU = 4;
  localparam int MW  = SW + $clog2(NF);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          samp_vld = 1'b0;
  logic [NF*SW-1:0] cur_in = '0;
  logic [NF-1:0] zone_en = '0;
  logic [MW-1:0] pickup = '0;
  logic [KW-1:0] k_frac = '0;
  logic [MW-1:0] iop_out;
  logic [MW-1:0] smooth_out;
  logic          operate_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int m_held, m_step, e_iop, e_op;
  bit m_first;

  always #10 clk = ~clk;

  busdiff_eval #(.N_FEED(NF), .SAMP_W(SW), .K_W(KW), .TAU_SAMP(TAU)) dut (
    .clk(clk), .rst(rst), .samp_vld(samp_vld), .cur_in(cur_in),
    .zone_en(zone_en), .pickup(pickup), .k_frac(k_frac),
    .iop_out(iop_out), .smooth_out(smooth_out), .operate_out(operate_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_held = 0; m_step = 0; m_first = 1'b1; e_iop = 0; e_op = 0;
  endtask

  task automatic do_samp(input int a, input int b, input int c, input logic [2:0] m,
                         input int k, input int pk,
                         input string t_iop, input string t_sm, input string t_op);
    int s, r, dec, v;
    int x [3];
    x[0] = a; x[1] = b; x[2] = c;
    s = 0; r = 0;
    for (int i = 0; i < 3; i++) begin
      if (m[i]) begin
        s += x[i];
        r += (x[i] < 0) ? -x[i] : x[i];
      end
    end
    e_iop = (s < 0) ? -s : s;
    dec = (m_held >= m_step) ? m_held - m_step : 0;
    if (m_first || r > dec) begin
      m_held = r; m_step = r / TAU;
    end else begin
      m_held = dec;
    end
    m_first = 1'b0;
    e_op = (e_iop > pk && e_iop * 256 > k * m_held) ? 1 : 0;
    @(negedge clk);
    v = c; cur_in[2*SW +: SW] = v[SW-1:0];
    v = b; cur_in[SW +: SW]   = v[SW-1:0];
    v = a; cur_in[0 +: SW]    = v[SW-1:0];
    zone_en = m; k_frac = KW'(k); pickup = MW'(pk);
    samp_vld = 1'b1;
    @(negedge clk);
    samp_vld = 1'b0;
    chk(t_iop, int'(iop_out), e_iop);
    chk(t_sm, int'(smooth_out), m_held);
    chk(t_op, int'(operate_out), e_op);
  endtask

  task automatic idle_check(input int seed);
    cur_in  = NF*SW'(seed * 7919);
    zone_en = 3'b111;
    pickup  = '0;
    k_frac  = '0;
    @(negedge clk);
    chk("R8 iop hold", int'(iop_out), e_iop);
    chk("R8 smooth hold", int'(smooth_out), m_held);
    chk("R8 operate hold", int'(operate_out), e_op);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    do_reset();
    chk("R9 iop reset", int'(iop_out), 0);
    chk("R9 smooth reset", int'(smooth_out), 0);
    chk("R9 operate reset", int'(operate_out), 0);

    // first sample after reset captures, even a zero restraint
    do_samp(0, 0, 0, 3'b000, 0, 0, "R9", "R9", "R9");

    // full negative scale on every feeder
    do_reset();
    do_samp(-16, -16, -16, 3'b111, 0, 0, "R3", "R3", "R3");

    // masking, raw restraint, decay, capture, clamp
    do_reset();
    do_samp(15, -16, 3, 3'b101, 0, 100, "R10", "R2", "R7");
    chk("R2 value", int'(smooth_out), 18);
    do_samp(15, -16, 3, 3'b000, 0, 0, "R10", "R5", "R7");
    chk("R5 value", int'(smooth_out), 14);
    do_samp(10, 10, 0, 3'b011, 0, 0, "R1", "R4", "R7");
    chk("R4 value", int'(smooth_out), 20);
    for (int i = 0; i < 5; i++) do_samp(0, 0, 0, 3'b111, 0, 0, "R1", "R6", "R7");
    chk("R6 value", int'(smooth_out), 0);
    idle_check(5);

    // pickup strict edge: iop 8, smooth 8, k=0
    do_reset();
    do_samp(8, 0, 0, 3'b001, 0, 8, "R1", "R2", "R7 pickup equal");
    chk("R7 pickup equal", int'(operate_out), 0);
    do_reset();
    do_samp(8, 0, 0, 3'b001, 0, 7, "R1", "R2", "R7 pickup above");
    chk("R7 pickup above", int'(operate_out), 1);
    // slope edge: iop 4, smooth 12
    do_reset();
    do_samp(8, -4, 0, 3'b011, 85, 0, "R1", "R2", "R7 slope below");
    chk("R7 slope below", int'(operate_out), 1);
    do_reset();
    do_samp(8, -4, 0, 3'b011, 86, 0, "R1", "R2", "R7 slope above");
    chk("R7 slope above", int'(operate_out), 0);

    // sweep all masks over a grid of sample triples
    do_reset();
    begin
      int idx;
      idx = 0;
      for (int m = 0; m < 8; m++)
        for (int a = -16; a < 16; a++)
          for (int b = -16; b < 16; b += 3)
            for (int c = -16; c < 16; c += 5) begin
              do_samp(a, b, c, 3'(m), (idx * 37) % 256, idx % 20, "R1", "R5", "R7");
              if (idx % 97 == 0) idle_check(idx);
              idx++;
            end
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule